// File: doc/BRIEF.md
# Serial Frame Receiver with Clock Return and I/Q Pairing

This block sits at the receiving end of a point-to-point serial message link and acts as the clock master. When the remote sender raises its ready line, the receiver starts a transfer clock made by dividing the system clock and drives it out to the sender. The sender changes its data line on each rising edge of that clock. The receiver takes in one bit at each falling edge and builds a fixed-length frame in a shift register. The transfer clock stops by itself once a full frame has been taken in. Before another transfer can begin, the ready line has to be seen low.

Completed frames go through a pairing stage that works on in-phase (I) and quadrature (Q) frames. With Q disabled, a frame is released at once as I data, and a second frame that follows inside the pairing window is thrown away. With Q enabled, the first frame is held until a second frame arrives as Q data, and the two are then released together. If the window closes with no second frame, nothing is released and the output enable is dropped. A transmit-inhibit input masks the output enable. The reset input is synchronous and returns the whole block to its power-up state.

Top module: `srx_rx`

## Requirements
- R1: While `rst` is high, and after it falls until a new transfer starts, `xfer_clk`, `frame_valid` and `out_en` are low, and `frame_i`, `frame_q` and `frame_pair` are zero. Reset taken in the middle of a transfer stops the transfer clock within one system clock.
- R2: With the receiver idle, `xfer_clk` goes high within 2 system clocks of `msg_rdy` going high, provided `msg_rdy` has been low at some point since the previous transfer started (or since reset). Holding `msg_rdy` high after a transfer does not start another one.
- R3: A transfer gives exactly `FRAME_BITS` pulses on `xfer_clk`. Each pulse lasts `CLK_DIV` system clocks and is high for the first `CLK_DIV/2` of them. After the last pulse the clock stays low.
- R4: `ser_data` is sampled on each falling edge of `xfer_clk`. The first bit received ends up in bit `FRAME_BITS-1` of the frame and the last bit in bit 0.
- R5: `q_en` is sampled when a first frame completes. If it is 0, `frame_valid` pulses high for exactly one system clock with `frame_i` equal to the frame, `frame_q` zero and `frame_pair` 0, and the output enable is set.
- R6: In I-only mode, a second frame whose transfer starts within `TIMEOUT` system clocks of the first frame completing is discarded. There is no `frame_valid` pulse, and the frame outputs and `out_en` are unchanged.
- R7: In Q mode, a second frame that starts inside the window produces one `frame_valid` pulse. With it, `frame_i` holds the first frame, `frame_q` holds the second and `frame_pair` is 1, and the output enable is set.
- R8: In Q mode, if no second transfer starts within `TIMEOUT` system clocks, there is no `frame_valid` pulse, the output enable is cleared, and `frame_i`, `frame_q` keep their previous values.
- R9: While `tx_inh` is high, `out_en` is low in the same cycle. Reception and frame release carry on as normal, and `out_en` comes back once `tx_inh` falls if the enable is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hard reset |
| msg_rdy | input | 1 | Sender's message-ready line |
| ser_data | input | 1 | Serial data from the sender |
| q_en | input | 1 | Quadrature frame required for this channel |
| tx_inh | input | 1 | Transmit inhibit; masks the output enable |
| xfer_clk | output | 1 | Transfer clock returned to the sender |
| frame_i | output | FRAME_BITS | Released in-phase frame |
| frame_q | output | FRAME_BITS | Released quadrature frame (zero in I-only mode) |
| frame_pair | output | 1 | Last release carried a Q frame |
| frame_valid | output | 1 | One-cycle pulse when a frame or a pair is released |
| out_en | output | 1 | Output enable |

## Verification
The assertions assume that `msg_rdy`, `ser_data`, `q_en` and `tx_inh` are synchronous to the system clock. They also assume the sender changes `ser_data` only just after a rising edge of `xfer_clk` and lowers `msg_rdy` only after the last falling edge of a frame. The bench follows this. It drives data a fraction of a nanosecond after each rising transfer edge and drops the ready line on the final falling edge. It starts every second frame well inside the pairing window, and it waits past the window before starting a new message. The only exception is the reset case, where the ready line is deliberately held high across reset.

// File: rtl/srx_pkg.sv
package srx_pkg;

    // Pairing phase of the I/Q stage
    typedef enum logic [1:0] {
        PH_FIRST  = 2'd0,  // waiting for the first frame of a message
        PH_GAP    = 2'd1,  // first frame held, window for a second transfer open
        PH_SECOND = 2'd2   // second transfer in progress
    } phase_e;

    // Number of system clocks the transfer clock stays high
    function automatic int high_len(input int div);
        return div / 2;
    endfunction

    // Counter width able to hold values 0..n-1
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/srx_clkgen.sv
module srx_clkgen
    import srx_pkg::*;
#(
    parameter int CLK_DIV    = 250,
    parameter int FRAME_BITS = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic msg_rdy,
    output logic xfer_clk,
    output logic start_p,
    output logic sample,
    output logic last
);
    localparam int HI = high_len(CLK_DIV);
    localparam int DW = cnt_w(CLK_DIV);
    localparam int BW = cnt_w(FRAME_BITS + 1);

    logic          busy;
    logic          armed;
    logic [DW-1:0] div_cnt;
    logic [BW-1:0] bit_cnt;
    logic          start_c;
    logic          end_c;

    assign start_c  = !busy && armed && msg_rdy;
    assign sample   = busy && (div_cnt == DW'(HI - 1));
    assign end_c    = busy && (div_cnt == DW'(CLK_DIV - 1));
    assign last     = sample && (bit_cnt == BW'(FRAME_BITS - 1));
    assign xfer_clk = busy && (div_cnt < DW'(HI));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            armed   <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            start_p <= 1'b0;
        end else begin
            start_p <= start_c;
            if (!msg_rdy) begin
                armed <= 1'b1;
            end
            if (start_c) begin
                busy    <= 1'b1;
                armed   <= 1'b0;
                div_cnt <= '0;
                bit_cnt <= '0;
            end else if (busy) begin
                div_cnt <= end_c ? '0 : div_cnt + 1'b1;
                if (sample) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (end_c && bit_cnt == BW'(FRAME_BITS)) begin
                    busy <= 1'b0;
                end
            end
        end
    end

    a_r2_start_needs_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(msg_rdy))
        else $error("R2: transfer started without ready");

    a_r3_bit_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bit_cnt <= BW'(FRAME_BITS)))
        else $error("R3: bit count overran the frame");

    a_r3_stop_full: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(bit_cnt) == BW'(FRAME_BITS)))
        else $error("R3: clock stopped before the frame was complete");

endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
    parameter int FRAME_BITS = 500
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sample,
    input  logic                  last,
    input  logic                  ser_data,
    output logic [FRAME_BITS-1:0] frame,
    output logic                  done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            frame <= '0;
            done  <= 1'b0;
        end else begin
            done <= sample && last;
            if (sample) begin
                frame <= {frame[FRAME_BITS-2:0], ser_data};
            end
        end
    end

    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("R4: frame-complete lasted more than one cycle");

    a_r4_done_after_sample: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(sample))
        else $error("R4: frame completed without a sample");

endmodule

// File: rtl/srx_pairing.sv
module srx_pairing
    import srx_pkg::*;
#(
    parameter int FRAME_BITS = 500,
    parameter int TIMEOUT    = 2500
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_p,
    input  logic                  done,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  q_en,
    output logic [FRAME_BITS-1:0] out_i,
    output logic [FRAME_BITS-1:0] out_q,
    output logic                  pair,
    output logic                  valid,
    output logic                  en
);
    localparam int TW = cnt_w(TIMEOUT);

    phase_e                phase;
    logic                  q_mode;
    logic [FRAME_BITS-1:0] stage_i;
    logic [TW-1:0]         tmo;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_FIRST;
            q_mode  <= 1'b0;
            stage_i <= '0;
            tmo     <= '0;
            out_i   <= '0;
            out_q   <= '0;
            pair    <= 1'b0;
            valid   <= 1'b0;
            en      <= 1'b0;
        end else begin
            valid <= 1'b0;
            unique case (phase)
                PH_FIRST: begin
                    if (done) begin
                        q_mode <= q_en;
                        tmo    <= '0;
                        phase  <= PH_GAP;
                        if (q_en) begin
                            stage_i <= frame;
                        end else begin
                            out_i <= frame;
                            out_q <= '0;
                            pair  <= 1'b0;
                            valid <= 1'b1;
                            en    <= 1'b1;
                        end
                    end
                end
                PH_GAP: begin
                    if (start_p) begin
                        phase <= PH_SECOND;
                    end else if (tmo == TW'(TIMEOUT - 1)) begin
                        phase <= PH_FIRST;
                        if (q_mode) begin
                            en <= 1'b0;
                        end
                    end else begin
                        tmo <= tmo + 1'b1;
                    end
                end
                PH_SECOND: begin
                    if (done) begin
                        phase <= PH_FIRST;
                        if (q_mode) begin
                            out_i <= stage_i;
                            out_q <= frame;
                            pair  <= 1'b1;
                            valid <= 1'b1;
                            en    <= 1'b1;
                        end
                    end
                end
                default: phase <= PH_FIRST;
            endcase
        end
    end

    a_r5_valid_after_frame: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(done))
        else $error("R5: release without a completed frame");

    a_r5_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid)
        else $error("R5: release strobe longer than one cycle");

    a_r7_pair_from_second: assert property (@(posedge clk) disable iff (rst)
        (valid && pair) |-> $past(phase == PH_SECOND))
        else $error("R7: pair released outside the second frame");

    a_r6_discard_keeps: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SECOND && done && !q_mode) |=> ($stable(out_i) && !valid))
        else $error("R6: unneeded second frame was not discarded");

endmodule

// File: rtl/srx_rx.sv
module srx_rx #(
    parameter int CLK_DIV    = 250,
    parameter int FRAME_BITS = 500,
    parameter int TIMEOUT    = 2500
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  msg_rdy,
    input  logic                  ser_data,
    input  logic                  q_en,
    input  logic                  tx_inh,
    output logic                  xfer_clk,
    output logic [FRAME_BITS-1:0] frame_i,
    output logic [FRAME_BITS-1:0] frame_q,
    output logic                  frame_pair,
    output logic                  frame_valid,
    output logic                  out_en
);
    logic                  start_p;
    logic                  sample;
    logic                  last;
    logic                  done;
    logic                  en_held;
    logic [FRAME_BITS-1:0] shreg;

    srx_clkgen #(.CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .msg_rdy  (msg_rdy),
        .xfer_clk (xfer_clk),
        .start_p  (start_p),
        .sample   (sample),
        .last     (last)
    );

    srx_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .sample   (sample),
        .last     (last),
        .ser_data (ser_data),
        .frame    (shreg),
        .done     (done)
    );

    srx_pairing #(.FRAME_BITS(FRAME_BITS), .TIMEOUT(TIMEOUT)) u_pairing (
        .clk     (clk),
        .rst     (rst),
        .start_p (start_p),
        .done    (done),
        .frame   (shreg),
        .q_en    (q_en),
        .out_i   (frame_i),
        .out_q   (frame_q),
        .pair    (frame_pair),
        .valid   (frame_valid),
        .en      (en_held)
    );

    assign out_en = en_held && !tx_inh;

    a_r9_inhibit: assert property (@(posedge clk) disable iff (rst)
        tx_inh |-> !out_en)
        else $error("R9: output enabled under inhibit");

endmodule

// File: tb/test_srx_rx.sv
module test_srx_rx;
    localparam int FB   = 16;
    localparam int DIV  = 4;
    localparam int TMO  = 40;
    localparam int HALF = DIV / 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          msg_rdy = 1'b0;
    logic          ser_data = 1'b0;
    logic          q_en = 1'b0;
    logic          tx_inh = 1'b0;
    logic          xfer_clk;
    logic [FB-1:0] frame_i;
    logic [FB-1:0] frame_q;
    logic          frame_pair;
    logic          frame_valid;
    logic          out_en;

    srx_rx #(.CLK_DIV(DIV), .FRAME_BITS(FB), .TIMEOUT(TMO)) i_srx_rx (
        .clk         (clk),
        .rst         (rst),
        .msg_rdy     (msg_rdy),
        .ser_data    (ser_data),
        .q_en        (q_en),
        .tx_inh      (tx_inh),
        .xfer_clk    (xfer_clk),
        .frame_i     (frame_i),
        .frame_q     (frame_q),
        .frame_pair  (frame_pair),
        .frame_valid (frame_valid),
        .out_en      (out_en)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct {
        bit            pair;
        logic [FB-1:0] i;
        logic [FB-1:0] q;
    } exp_t;
    exp_t sb[$];

    // Scoreboard monitor: each release pops one expected item
    always @(negedge clk) begin
        if (!rst && frame_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6/R8 unexpected release", 64'(frame_i), 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(frame_i == e.i, "R4/R5 frame_i", 64'(frame_i), 64'(e.i));
                check(frame_q == e.q, "R7 frame_q", 64'(frame_q), 64'(e.q));
                check(frame_pair == e.pair, "R7 frame_pair",
                      64'(frame_pair), 64'(e.pair));
            end
        end
    end

    int rises = 0;
    int hi_cyc = 0;
    always @(posedge xfer_clk) rises++;
    always @(negedge clk) if (xfer_clk) hi_cyc++;

    task automatic push(input bit pr, input logic [FB-1:0] a, input logic [FB-1:0] b);
        exp_t e;
        e.pair = pr;
        e.i = a;
        e.q = b;
        sb.push_back(e);
    endtask

    task automatic send_frame(input logic [FB-1:0] d, input bit hold);
        int lat;
        int r0;
        int h0;
        @(negedge clk);
        r0 = rises;
        h0 = hi_cyc;
        msg_rdy = 1'b1;
        lat = 0;
        while (!xfer_clk) begin
            @(negedge clk);
            lat++;
        end
        check(lat <= 2, "R2 clock start latency", 64'(lat), 64'd2);
        ser_data = d[FB-1];
        for (int k = FB - 2; k >= 0; k--) begin
            @(posedge xfer_clk);
            #1 ser_data = d[k];
        end
        @(negedge xfer_clk);
        if (!hold) msg_rdy = 1'b0;
        repeat (DIV) @(negedge clk);
        check(rises - r0 == FB, "R3 pulse count", 64'(rises - r0), 64'(FB));
        check(hi_cyc - h0 == FB * HALF, "R3 high time",
              64'(hi_cyc - h0), 64'(FB * HALF));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int r0;
        // R1: state during and after reset
        idle(5);
        check(!xfer_clk && !frame_valid && !out_en, "R1 outputs in reset",
              64'({xfer_clk, frame_valid, out_en}), 64'd0);
        rst = 1'b0;
        idle(3 * DIV);
        check(!xfer_clk && !out_en && frame_i == 0 && frame_q == 0 && !frame_pair,
              "R1 outputs after reset", 64'({xfer_clk, out_en, frame_pair}), 64'd0);

        // R5: I-only release
        q_en = 1'b0;
        push(1'b0, 16'hA5C3, 16'h0000);
        send_frame(16'hA5C3, 1'b0);
        idle(4);
        check(out_en, "R5 enable set", 64'(out_en), 64'd1);

        // R6: second frame inside window is discarded
        idle(3);
        send_frame(16'h1234, 1'b0);
        idle(TMO + 10);
        check(frame_i == 16'hA5C3 && frame_q == 0, "R6 outputs unchanged",
              64'(frame_i), 64'hA5C3);
        check(out_en, "R6 enable unchanged", 64'(out_en), 64'd1);

        // R2: ready held high does not restart the clock
        push(1'b0, 16'h8001, 16'h0000);
        send_frame(16'h8001, 1'b1);
        r0 = rises;
        idle(TMO + 10);
        check(rises == r0, "R2 no restart while ready held", 64'(rises - r0), 64'd0);
        msg_rdy = 1'b0;
        idle(4);

        // R7: Q pair
        q_en = 1'b1;
        push(1'b1, 16'h0F0F, 16'hF00D);
        send_frame(16'h0F0F, 1'b0);
        idle(3);
        send_frame(16'hF00D, 1'b0);
        idle(4);
        check(out_en && frame_pair, "R7 enable and pair flag",
              64'({out_en, frame_pair}), 64'd3);
        idle(TMO + 10);

        // R8: Q missing
        send_frame(16'h5555, 1'b0);
        idle(TMO + 10);
        check(!out_en, "R8 enable cleared", 64'(out_en), 64'd0);
        check(frame_i == 16'h0F0F && frame_q == 16'hF00D, "R8 outputs kept",
              64'({frame_i, frame_q}), 64'h0F0FF00D);

        // R9: inhibit
        q_en = 1'b0;
        push(1'b0, 16'hC001, 16'h0000);
        send_frame(16'hC001, 1'b0);
        idle(TMO + 10);
        check(out_en, "R9 enable before inhibit", 64'(out_en), 64'd1);
        tx_inh = 1'b1;
        #1;
        check(!out_en, "R9 inhibit immediate", 64'(out_en), 64'd0);
        push(1'b0, 16'h7E57, 16'h0000);
        send_frame(16'h7E57, 1'b0);
        idle(4);
        check(frame_i == 16'h7E57 && !out_en, "R9 reception under inhibit",
              64'({out_en, frame_i}), 64'h7E57);
        idle(TMO + 10);
        tx_inh = 1'b0;
        #1;
        check(out_en, "R9 enable returns", 64'(out_en), 64'd1);

        // R1: hard reset mid-transfer
        @(negedge clk);
        msg_rdy = 1'b1;
        idle(10);
        rst = 1'b1;
        idle(1);
        check(!xfer_clk && !out_en && frame_i == 0, "R1 reset mid-transfer",
              64'({xfer_clk, out_en, frame_i}), 64'd0);
        idle(3);
        rst = 1'b0;
        r0 = rises;
        idle(3 * DIV);
        check(rises == r0 && !xfer_clk, "R1 idle after reset with ready high",
              64'(rises - r0), 64'd0);
        msg_rdy = 1'b0;
        idle(2);
        push(1'b0, 16'hBEEF, 16'h0000);
        send_frame(16'hBEEF, 1'b0);
        idle(TMO + 10);

        check(sb.size() == 0, "R5/R7 all releases seen", 64'(sb.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule